// File: doc/BRIEF.md
# Media Element Arithmetic Unit

This unit is a one-element arithmetic stage for audio and video processing. It has four operations: rounding average, absolute difference, minimum and maximum. Each operation runs on an 8-, 16- or 32-bit element held in the low bits of a 32-bit operand. A single flag chooses whether the element is read as two's-complement or as unsigned.

An operation is issued by raising `inValid` for one cycle together with both operands, the opcode, the width code and the signedness flag. One clock edge later `resValid` goes high and `result` holds the element result, widened to 32 bits. The result register keeps its value until the next issued operation. The average is built on a sum that is one bit wider than the widest element, so the carry is never lost before the halving.

Top module: `media_elem_alu`

## Requirements
- R1: `widthSel` picks the element width: 00 is 8 bits, 01 is 16 bits, 10 is 32 bits. The code 11 behaves as 32 bits.
- R10: `opSel` picks the operation: 00 is rounding average, 01 is absolute difference, 10 is minimum, 11 is maximum.
- R2: The average returns floor((a + b + 1) / 2) of the two element values, truncated to the element width. No overflow occurs at any width. In signed mode the halving rounds toward minus infinity.
- R3: Absolute difference returns the magnitude of a - b as an unsigned value of the element width, in both signed and unsigned mode.
- R4: Minimum returns the smaller element value under the selected signedness.
- R5: Maximum returns the larger element value under the selected signedness.
- R6: Only the low element-width bits of each operand take part. In signed mode, bit width-1 is the sign bit. Operand bits above the element width do not affect the result.
- R7: Results of average, minimum and maximum are sign-extended to 32 bits in signed mode and zero-extended in unsigned mode. Absolute difference is always zero-extended.
- R8: `resValid` is high exactly in the cycle after `inValid` was sampled high. `result` keeps its value while no operation is issued.
- R9: While reset is asserted, `resValid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issues an operation this cycle |
| opA | input | 32 | First operand; element in the low bits |
| opB | input | 32 | Second operand; element in the low bits |
| opSel | input | 2 | Operation code |
| widthSel | input | 2 | Element width code |
| isSigned | input | 1 | 1 selects two's-complement elements |
| resValid | output | 1 | Result register was loaded on the last edge |
| result | output | 32 | Registered result, widened to 32 bits |

## Verification
Some properties are checked by assertions on every issued operation:
- the width decode is one-hot;
- the widened average always lies between the smaller and the larger operand, which shows the carry was kept;
- the absolute difference is never negative in the widened arithmetic;
- unsigned-extended results carry no bits above the element width;
- `resValid` follows `inValid` by exactly one cycle.

The exact values still need the bench's scenarios. These cover:
- rounding direction on odd sums;
- saturating corner pairs such as both operands at the extreme value;
- signed magnitudes that span the whole element range;
- immunity to junk in the upper operand bits;
- the treatment of the spare width code.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;

  // Number of supported element widths: 8 << index
  localparam int NUM_W = 3;

  typedef enum logic [1:0] {
    OP_AVG  = 2'b00,
    OP_ABSD = 2'b01,
    OP_MIN  = 2'b10,
    OP_MAX  = 2'b11
  } opcode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;  // load the result register
    logic [3:0]       opHot;    // one-hot operation, index = opcode
    logic [NUM_W-1:0] wHot;     // one-hot element width
    logic             sgn;      // interpret elements as signed
    logic             sextOut;  // sign-extend the result to the datapath
  } alu_ctrl_t;

endpackage

// File: rtl/media_alu_ctrl.sv
module media_alu_ctrl
  import media_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic [1:0] widthSel,
  input  logic       isSigned,
  output alu_ctrl_t  ctl,
  output logic       resValid
);

  localparam int WSEL_MAX = NUM_W - 1;

  logic [1:0] widthIdx;

  always_comb begin
    // R1: codes beyond the widest width fold onto the widest
    if (int'(widthSel) > WSEL_MAX) widthIdx = 2'(WSEL_MAX);
    else                           widthIdx = widthSel;
  end

  always_comb begin
    ctl         = '0;
    ctl.capture = inValid;
    // R10: opcode decode
    ctl.opHot   = 4'b0001 << opSel;
    ctl.wHot    = NUM_W'(1) << widthIdx;
    ctl.sgn     = isSigned;
    // R7: absolute difference is a magnitude, never sign-extended
    ctl.sextOut = isSigned && (opcode_e'(opSel) != OP_ABSD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end

  // R8: valid follows issue by one cycle
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (resValid == $past(inValid)));

endmodule

// File: rtl/media_alu_dp.sv
module media_alu_dp
  import media_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  alu_ctrl_t         ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int EXT_W = DATA_W + 1;  // element plus sign/carry room
  localparam int SUM_W = EXT_W + 1;

  logic [EXT_W-1:0]  laneA    [NUM_W];
  logic [EXT_W-1:0]  laneB    [NUM_W];
  logic [DATA_W-1:0] laneMask [NUM_W];
  logic [DATA_W-1:0] laneSign [NUM_W];

  // R6: one widening lane per element width, using only its low bits
  for (genvar g = 0; g < NUM_W; g++) begin : g_lane
    localparam int LW = 8 << g;
    localparam logic [SUM_W-1:0] MASK_WIDE = (SUM_W'(1) << LW) - SUM_W'(1);
    assign laneA[g]    = {{(EXT_W-LW){ctl.sgn & opA[LW-1]}}, opA[LW-1:0]};
    assign laneB[g]    = {{(EXT_W-LW){ctl.sgn & opB[LW-1]}}, opB[LW-1:0]};
    assign laneMask[g] = MASK_WIDE[DATA_W-1:0];
    assign laneSign[g] = DATA_W'(1) << (LW - 1);
  end

  logic [EXT_W-1:0]  extA, extB;
  logic [DATA_W-1:0] elemMask, signBitSel;

  always_comb begin
    extA       = '0;
    extB       = '0;
    elemMask   = '0;
    signBitSel = '0;
    for (int i = 0; i < NUM_W; i++) begin
      if (ctl.wHot[i]) begin
        extA       = extA | laneA[i];
        extB       = extB | laneB[i];
        elemMask   = elemMask | laneMask[i];
        signBitSel = signBitSel | laneSign[i];
      end
    end
  end

  // Arithmetic core on widened operands
  logic [SUM_W-1:0]  sumWide;
  logic [SUM_W-1:0]  avgWide;
  logic              aGtB;
  logic [EXT_W-1:0]  diffWide, minWide, maxWide;
  logic [DATA_W-1:0] rawRes, nextRes;

  always_comb begin
    // R2: carry kept in the extra top bit, then arithmetic halving
    sumWide  = {extA[EXT_W-1], extA} + {extB[EXT_W-1], extB} + SUM_W'(1);
    avgWide  = SUM_W'($signed(sumWide) >>> 1);
    aGtB     = $signed(extA) > $signed(extB);
    diffWide = aGtB ? (extA - extB) : (extB - extA);
    minWide  = aGtB ? extB : extA;
    maxWide  = aGtB ? extA : extB;
    unique case (1'b1)
      ctl.opHot[OP_ABSD]: rawRes = diffWide[DATA_W-1:0];
      ctl.opHot[OP_MIN]:  rawRes = minWide[DATA_W-1:0];
      ctl.opHot[OP_MAX]:  rawRes = maxWide[DATA_W-1:0];
      default:            rawRes = avgWide[DATA_W-1:0];
    endcase
    // R7: truncate to the element, then widen
    nextRes = rawRes & elemMask;
    if (ctl.sextOut && ((rawRes & signBitSel) != '0)) nextRes = nextRes | ~elemMask;
  end

  logic [DATA_W-1:0] resMask;
  logic              resSext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      resMask <= '0;
      resSext <= 1'b0;
    end else if (ctl.capture) begin
      result  <= nextRes;
      resMask <= elemMask;
      resSext <= ctl.sextOut;
    end
  end

  always_comb begin
    if (rstN && ctl.capture) begin
      // R1: exactly one width lane selected
      a_r1_width_onehot: assert ($onehot(ctl.wHot));
      // R2: widened average stays between the operands, so no overflow
      a_r2_no_overflow: assert (
        ($signed(avgWide) >= $signed({minWide[EXT_W-1], minWide})) &&
        ($signed(avgWide) <= $signed({maxWide[EXT_W-1], maxWide})));
      // R3: magnitude never negative
      a_r3_abs_nonneg: assert (diffWide[EXT_W-1] == 1'b0);
    end
  end

  // R7: zero-extended results have nothing above the element
  a_r7_zero_ext_high: assert property (@(posedge clk) disable iff (!rstN)
    !resSext |-> ((result & ~resMask) == '0));

endmodule

// File: rtl/media_elem_alu.sv
module media_elem_alu
  import media_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        opSel,
  input  logic [1:0]        widthSel,
  input  logic              isSigned,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);

  alu_ctrl_t ctl;

  media_alu_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .widthSel (widthSel),
    .isSigned (isSigned),
    .ctl      (ctl),
    .resValid (resValid)
  );

  media_alu_dp #(.DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

  // R9: reset state at the ports
  a_r9_reset_idle: assert property (@(posedge clk)
    !rstN |-> (!resValid && result == '0));

endmodule

// File: tb/test_media_elem_alu.sv
module test_media_elem_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  opSel = '0, widthSel = '0;
  logic        isSigned = 1'b0;
  logic        resValid;
  logic [31:0] result;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  media_elem_alu i_media_elem_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .opSel(opSel), .widthSel(widthSel), .isSigned(isSigned),
    .resValid(resValid), .result(result)
  );

  // Reference model written from the requirements
  function automatic logic [31:0] refModel(logic [31:0] a, logic [31:0] b,
                                           logic [1:0] op, logic [1:0] w, logic s);
    int n;
    longint mask, ea, eb, r, res;
    n = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;          // R1
    mask = (longint'(1) << n) - 1;
    ea = longint'(a) & mask;                                 // R6
    eb = longint'(b) & mask;
    if (s && ea[n-1]) ea = ea - (longint'(1) << n);
    if (s && eb[n-1]) eb = eb - (longint'(1) << n);
    case (op)                                                // R10
      2'b00:   r = (ea + eb + 1) >>> 1;                      // R2
      2'b01:   r = (ea > eb) ? ea - eb : eb - ea;            // R3
      2'b10:   r = (ea < eb) ? ea : eb;                      // R4
      default: r = (ea > eb) ? ea : eb;                      // R5
    endcase
    res = r & mask;                                          // R7
    if (s && op != 2'b01 && res[n-1]) res = res | ~mask;
    return res[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(string req, logic [31:0] a, logic [31:0] b,
                       logic [1:0] op, logic [1:0] w, logic s);
    @(negedge clk);
    opA = a; opB = b; opSel = op; widthSel = w; isSigned = s; inValid = 1'b1;
    @(posedge clk);
    #1;
    check({req, " valid"}, {31'd0, resValid}, 32'd1);
    check(req, result, refModel(a, b, op, w, s));
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idleCheck(logic [31:0] held);
    @(negedge clk);
    opA = $urandom; opB = $urandom; opSel = 2'($urandom); inValid = 1'b0;
    @(posedge clk);
    #1;
    check("R8 idle valid", {31'd0, resValid}, 32'd0);
    check("R8 result held", result, held);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", {31'd0, resValid}, 32'd0);
    check("R9 reset result", result, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: unsigned carry kept, rounding up
    issue("R2 u8 max avg", 32'h0000_00FF, 32'h0000_00FF, 2'b00, 2'b00, 1'b0);
    issue("R2 u8 odd avg", 32'h0000_0001, 32'h0000_0002, 2'b00, 2'b00, 1'b0);
    issue("R2 u32 max avg", 32'hFFFF_FFFF, 32'hFFFF_FFFE, 2'b00, 2'b10, 1'b0);
    // R2/R7: signed extremes
    issue("R2 s8 neg avg", 32'h0000_0080, 32'h0000_0080, 2'b00, 2'b00, 1'b1);
    issue("R2 s32 pos avg", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 2'b10, 1'b1);
    issue("R2 s16 floor", 32'h0000_FFFF, 32'h0000_FFFE, 2'b00, 2'b01, 1'b1);
    // R3: full-range signed magnitude, zero-extended
    issue("R3 s8 absd", 32'h0000_007F, 32'h0000_0080, 2'b01, 2'b00, 1'b1);
    issue("R3 s32 absd", 32'h8000_0000, 32'h7FFF_FFFF, 2'b01, 2'b10, 1'b1);
    issue("R3 u16 absd", 32'h0000_0003, 32'h0000_FFFF, 2'b01, 2'b01, 1'b0);
    // R4/R5: signedness changes ordering
    issue("R4 s8 min", 32'h0000_0080, 32'h0000_0001, 2'b10, 2'b00, 1'b1);
    issue("R4 u8 min", 32'h0000_0080, 32'h0000_0001, 2'b10, 2'b00, 1'b0);
    issue("R5 s16 max", 32'h0000_8000, 32'h0000_7FFF, 2'b11, 2'b01, 1'b1);
    issue("R5 u32 max", 32'h8000_0000, 32'h7FFF_FFFF, 2'b11, 2'b10, 1'b0);
    // R6: junk above the element is ignored
    issue("R6 junk high s8", 32'hABCD_EF05, 32'h1234_56FB, 2'b11, 2'b00, 1'b1);
    issue("R6 junk high u16", 32'hFFFF_0010, 32'h0000_0020, 2'b00, 2'b01, 1'b0);
    // R1: spare width code acts as 32 bits
    issue("R1 code11 max", 32'h8000_0000, 32'h0000_0001, 2'b11, 2'b11, 1'b1);
    issue("R1 code11 avg", 32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 2'b11, 1'b0);
    // R8: result holds while idle
    issue("R8 prep", 32'h0000_0042, 32'h0000_0010, 2'b01, 2'b00, 1'b0);
    idleCheck(32'h0000_0032);

    // R10/R7: random mix
    for (int i = 0; i < 400; i++) begin
      issue("R10 random", $urandom, $urandom, 2'($urandom), 2'($urandom % 3), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule